// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Timing Engine

This block is the master-side sequencer for a 16-bit peripheral bus on which address and data share the same lines. The bus uses four active-low strobes. A transfer request carries a 32-bit halfword address, a halfword count and a direction. From it, the engine drives the upper address half and the lower address half in turn, each latched by the falling edge of its own address-latch strobe. It then waits a programmable latency, and after that moves one halfword per read or write strobe. Each strobe has a programmable low time and a programmable high (release) time.

Consecutive halfwords inside one page move with strobes only. When the next halfword starts a new page, the engine raises the high address-latch strobe and sends the address again. The engine holds two timing sets, each with a latency, a low time, a release time and a page-size field. It picks one of the two from the starting address of the request. On reads, a device that answers asserts a drive-valid input. If no device answers, the engine returns the low half of the most recently issued page address, which models an open bus.

The engine sits between a transfer controller and the external pins. The controller starts a transfer with a one-cycle request, supplies write data until each word is taken, and collects read words as they are flagged valid.

Top module: `mbus_timing_engine`

## Requirements
- R1: After reset, all four strobes are high, ad_oe is low, and busy and done are low.
- R2: Each address phase is two cycles. In the first cycle, ad_out carries address bits 31:16 with both latch strobes high. In the second cycle, aleh_n falls, ad_out carries bits 15:0, and alel_n is still high. alel_n falls in the following cycle.
- R3: After alel_n falls, the first strobe of a page falls once alel_n has been low, with both strobes high, for exactly lat+1 cycles.
- R4: Every read or write strobe stays low for exactly pwd+1 cycles.
- R5: After every strobe, the strobes stay high for exactly rls+1 cycles before the next strobe, a new address phase, or the end of the transfer.
- R6: Between halfwords of the same page, aleh_n and alel_n stay low and no address is sent. When the next halfword address starts a new page, aleh_n rises for one cycle and a new address phase presents that address.
- R7: A request whose start address lies in 0x0500_0000–0x05FF_FFFF or 0x0800_0000–0x0FFF_FFFF uses timing set 2 for the whole transfer. Any other start address uses set 1.
- R8: On writes, ad_oe is high and ad_out equals wr_data while wr_n is low. wr_take pulses in the last low cycle of each word, once per word.
- R9: On reads, ad_oe is low while rd_n is low. One cycle after rd_n rises, rd_valid pulses. rd_data then holds ad_in if ad_in_drv was high in the last low cycle, and otherwise holds bits 15:0 of the latest issued page address.
- R10: done pulses for a single cycle, one clock after the last release cycle of the final word. In that cycle both latch strobes are high and busy is low.
- R11: A request is ignored while busy is high, and a request with a count of zero is ignored.
- R12: A page spans 2^(pgs+2) bytes, where pgs is the 4-bit page field of the active timing set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set1_lat | input | 8 | Timing set 1 latency |
| set1_pwd | input | 8 | Timing set 1 strobe low time |
| set1_rls | input | 2 | Timing set 1 release time |
| set1_pgs | input | 4 | Timing set 1 page-size field |
| set2_lat | input | 8 | Timing set 2 latency |
| set2_pwd | input | 8 | Timing set 2 strobe low time |
| set2_rls | input | 2 | Timing set 2 release time |
| set2_pgs | input | 4 | Timing set 2 page-size field |
| req_valid | input | 1 | Transfer request strobe |
| req_addr | input | 32 | Start halfword address (bit 0 ignored) |
| req_count | input | 16 | Number of halfwords |
| req_write | input | 1 | 1 for write, 0 for read |
| wr_data | input | 16 | Write halfword, held until wr_take |
| wr_take | output | 1 | Current write halfword consumed |
| rd_data | output | 16 | Read halfword |
| rd_valid | output | 1 | rd_data valid |
| ad_in | input | 16 | Bus lines as seen from the pins |
| ad_in_drv | input | 1 | A device is driving the bus |
| ad_out | output | 16 | Value driven onto the bus lines |
| ad_oe | output | 1 | Bus output enable |
| aleh_n | output | 1 | High address latch strobe |
| alel_n | output | 1 | Low address latch strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished pulse |

## Verification
The hardest case to reach from the ports is a page crossing in the middle of a transfer. The crossing must happen right after a release period, and the re-sent address must carry the page base, which then becomes the open-bus value. The stimulus reaches it with small page fields (two- and four-halfword pages) and start addresses just below a page edge, including one transfer that runs across a timing-set boundary. A pin monitor measures every low and high interval and checks each latched address against a page walk computed in the bench. A directed run with latency, low time and release time all at zero covers the shortest cycle counts. A run that keeps asserting competing requests while busy shows that they change neither the timing nor the number of address phases.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  parameter int LAT_W = 8;
  parameter int PWD_W = 8;
  parameter int RLS_W = 2;
  parameter int PGS_W = 4;

  typedef struct packed {
    logic [LAT_W-1:0] lat;
    logic [PWD_W-1:0] pwd;
    logic [RLS_W-1:0] rls;
    logic [PGS_W-1:0] pgs;
  } bus_timing_t;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_AHI  = 3'd1,
    PH_ALO  = 3'd2,
    PH_LAT  = 3'd3,
    PH_STRB = 3'd4,
    PH_REL  = 3'd5
  } bus_phase_e;
endpackage

// File: rtl/mbus_domain_sel.sv
module mbus_domain_sel
  import mbus_pkg::*;
#(
  parameter int AW = 32,
  parameter int NWIN = 2,
  parameter logic [NWIN*AW-1:0] WIN_BASE = {32'h0800_0000, 32'h0500_0000},
  parameter logic [NWIN*AW-1:0] WIN_LAST = {32'h0FFF_FFFF, 32'h05FF_FFFF}
) (
  input  logic [AW-1:0] addr,
  input  bus_timing_t   set1,
  input  bus_timing_t   set2,
  output bus_timing_t   chosen
);
  logic [NWIN-1:0] win_hit;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign win_hit[w] = (addr >= WIN_BASE[w*AW +: AW]) && (addr <= WIN_LAST[w*AW +: AW]);
  end

  always_comb begin
    chosen = (|win_hit) ? set2 : set1;
  end
endmodule

// File: rtl/mbus_addr_track.sv
module mbus_addr_track
  import mbus_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int CNTW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    load_addr,
  input  logic [CNTW-1:0]  load_count,
  input  logic             advance,
  input  logic             issue,
  input  logic [PGS_W-1:0] pgs,
  output logic [AW-1:0]    cur_addr,
  output logic [DW-1:0]    page_lo,
  output logic             last_word,
  output logic             page_cross
);
  localparam int SHW = $clog2(AW) + 1;

  logic [AW-1:0]   addr_q, addr_d, next_addr, page_mask;
  logic [CNTW-1:0] left_q, left_d;
  logic [DW-1:0]   page_q, page_d;
  logic [SHW-1:0]  shamt;

  always_comb begin
    next_addr  = addr_q + AW'(2);
    shamt      = SHW'(pgs) + SHW'(2);
    page_mask  = (AW'(1) << shamt) - AW'(1);
    page_cross = (next_addr & page_mask) == '0;
    last_word  = left_q == CNTW'(1);
    addr_d = addr_q;
    left_d = left_q;
    page_d = page_q;
    if (load) begin
      addr_d = {load_addr[AW-1:1], 1'b0};
      left_d = load_count;
    end else if (advance) begin
      addr_d = next_addr;
      left_d = left_q - CNTW'(1);
    end
    if (issue) begin
      page_d = addr_q[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
      page_q <= '0;
    end else begin
      if (load || advance) begin
        addr_q <= addr_d;
        left_q <= left_d;
      end
      if (issue) begin
        page_q <= page_d;
      end
    end
  end

  assign cur_addr = addr_q;
  assign page_lo  = page_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> $stable(addr_q)); // R6
endmodule

// File: rtl/mbus_phase_ctrl.sv
module mbus_phase_ctrl
  import mbus_pkg::*;
#(
  parameter int CW = (LAT_W > PWD_W) ? LAT_W : PWD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LAT_W-1:0] lat,
  input  logic [PWD_W-1:0] pwd,
  input  logic [RLS_W-1:0] rls,
  input  logic             last_word,
  input  logic             page_cross,
  output bus_phase_e       phase,
  output logic             strb_last,
  output logic             rel_last,
  output logic             done
);
  bus_phase_e    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          lat_last;

  always_comb begin
    lat_last  = (ph_q == PH_LAT)  && (cnt_q == CW'(lat));
    strb_last = (ph_q == PH_STRB) && (cnt_q == CW'(pwd));
    rel_last  = (ph_q == PH_REL)  && (cnt_q == CW'(rls));
    done_d    = rel_last && last_word;
    ph_d  = ph_q;
    cnt_d = cnt_q + CW'(1);
    unique case (ph_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (start) ph_d = PH_AHI;
      end
      PH_AHI: begin
        cnt_d = '0;
        ph_d  = PH_ALO;
      end
      PH_ALO: begin
        cnt_d = '0;
        ph_d  = PH_LAT;
      end
      PH_LAT: begin
        if (lat_last) begin
          cnt_d = '0;
          ph_d  = PH_STRB;
        end
      end
      PH_STRB: begin
        if (strb_last) begin
          cnt_d = '0;
          ph_d  = PH_REL;
        end
      end
      PH_REL: begin
        if (rel_last) begin
          cnt_d = '0;
          if (last_word)       ph_d = PH_IDLE;
          else if (page_cross) ph_d = PH_AHI;
          else                 ph_d = PH_STRB;
        end
      end
      default: begin
        cnt_d = '0;
        ph_d  = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign phase = ph_q;
  assign done  = done_q;

  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_LAT && cnt_q != CW'(lat)) |=> (ph_q == PH_LAT)); // R3
  AST_STRB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_STRB && cnt_q != CW'(pwd)) |=> (ph_q == PH_STRB)); // R4
  AST_REL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_REL && cnt_q != CW'(rls)) |=> (ph_q == PH_REL)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R10
endmodule

// File: rtl/mbus_timing_engine.sv
module mbus_timing_engine
  import mbus_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int CNTW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LAT_W-1:0] set1_lat,
  input  logic [PWD_W-1:0] set1_pwd,
  input  logic [RLS_W-1:0] set1_rls,
  input  logic [PGS_W-1:0] set1_pgs,
  input  logic [LAT_W-1:0] set2_lat,
  input  logic [PWD_W-1:0] set2_pwd,
  input  logic [RLS_W-1:0] set2_rls,
  input  logic [PGS_W-1:0] set2_pgs,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic [CNTW-1:0]  req_count,
  input  logic             req_write,
  input  logic [DW-1:0]    wr_data,
  output logic             wr_take,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  input  logic [DW-1:0]    ad_in,
  input  logic             ad_in_drv,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic             aleh_n,
  output logic             alel_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic             busy,
  output logic             done
);
  localparam int HI_LSB = AW - DW;

  logic [1:0]  rst_pipe;
  logic        rst_int_n;
  bus_timing_t sel_tim, tim_q, tim_d;
  logic        wr_q, wr_d;
  logic [DW-1:0] rdat_q, rdat_d;
  logic        rval_q, rval_d;
  logic        start, rd_cap;
  bus_phase_e  phase;
  logic        strb_last, rel_last, last_word, page_cross;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] page_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  mbus_domain_sel #(.AW(AW)) u_dsel (
    .addr   (req_addr),
    .set1   ({set1_lat, set1_pwd, set1_rls, set1_pgs}),
    .set2   ({set2_lat, set2_pwd, set2_rls, set2_pgs}),
    .chosen (sel_tim)
  );

  always_comb begin
    busy   = phase != PH_IDLE;
    start  = (phase == PH_IDLE) && req_valid && (req_count != '0);
    rd_cap = strb_last && !wr_q;
    tim_d  = start ? sel_tim : tim_q;
    wr_d   = start ? req_write : wr_q;
    rdat_d = rd_cap ? (ad_in_drv ? ad_in : page_lo) : rdat_q;
    rval_d = rd_cap;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tim_q  <= '0;
      wr_q   <= 1'b0;
      rdat_q <= '0;
      rval_q <= 1'b0;
    end else begin
      if (start) begin
        tim_q <= tim_d;
        wr_q  <= wr_d;
      end
      if (rd_cap) rdat_q <= rdat_d;
      rval_q <= rval_d;
    end
  end

  mbus_addr_track #(.AW(AW), .DW(DW), .CNTW(CNTW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load       (start),
    .load_addr  (req_addr),
    .load_count (req_count),
    .advance    (rel_last),
    .issue      (phase == PH_ALO),
    .pgs        (tim_q.pgs),
    .cur_addr   (cur_addr),
    .page_lo    (page_lo),
    .last_word  (last_word),
    .page_cross (page_cross)
  );

  mbus_phase_ctrl u_phase (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .lat        (tim_q.lat),
    .pwd        (tim_q.pwd),
    .rls        (tim_q.rls),
    .last_word  (last_word),
    .page_cross (page_cross),
    .phase      (phase),
    .strb_last  (strb_last),
    .rel_last   (rel_last),
    .done       (done)
  );

  always_comb begin
    aleh_n  = !(phase inside {PH_ALO, PH_LAT, PH_STRB, PH_REL});
    alel_n  = !(phase inside {PH_LAT, PH_STRB, PH_REL});
    rd_n    = !((phase == PH_STRB) && !wr_q);
    wr_n    = !((phase == PH_STRB) && wr_q);
    ad_oe   = (phase == PH_AHI) || (phase == PH_ALO) || ((phase == PH_STRB) && wr_q);
    wr_take = strb_last && wr_q;
    ad_out  = '0;
    if (phase == PH_AHI)              ad_out = cur_addr[AW-1:HI_LSB];
    else if (phase == PH_ALO)         ad_out = cur_addr[DW-1:0];
    else if (phase == PH_STRB && wr_q) ad_out = wr_data;
  end

  assign rd_data  = rdat_q;
  assign rd_valid = rval_q;

  AST_STROBE_UNDER_ALE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!rd_n || !wr_n) |-> (!aleh_n && !alel_n)); // R3
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_n |-> !ad_oe); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> (aleh_n && alel_n && !busy)); // R10
  AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |=> $stable(tim_q)); // R11
endmodule

// File: tb/mbus_timing_engine_test.sv
module mbus_timing_engine_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [7:0]  c1_lat, c1_pwd, c2_lat, c2_pwd;
  logic [1:0]  c1_rls, c2_rls;
  logic [3:0]  c1_pgs, c2_pgs;
  logic        req_valid, req_write, ad_in_drv;
  logic [31:0] req_addr;
  logic [15:0] req_count, wr_data, ad_in;
  logic        wr_take, rd_valid, ad_oe, aleh_n, alel_n, rd_n, wr_n, busy, done;
  logic [15:0] rd_data, ad_out;

  mbus_timing_engine uut (
    .clk(clk), .rst_n(rst_n),
    .set1_lat(c1_lat), .set1_pwd(c1_pwd), .set1_rls(c1_rls), .set1_pgs(c1_pgs),
    .set2_lat(c2_lat), .set2_pwd(c2_pwd), .set2_rls(c2_rls), .set2_pgs(c2_pgs),
    .req_valid(req_valid), .req_addr(req_addr), .req_count(req_count), .req_write(req_write),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .ad_in(ad_in), .ad_in_drv(ad_in_drv), .ad_out(ad_out), .ad_oe(ad_oe),
    .aleh_n(aleh_n), .alel_n(alel_n), .rd_n(rd_n), .wr_n(wr_n), .busy(busy), .done(done)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expectations shared with the pin monitor
  int exp_lat, exp_pwd, exp_rls, exp_words;
  logic [15:0] exp_hi [16];
  logic [15:0] exp_lo [16];
  logic [15:0] exp_rd [16];
  int ph_idx, word_cnt, rd_idx, take_cnt;
  bit rd_oe_bad;

  // pin monitor: samples on the falling edge
  initial begin
    bit p_aleh, p_alel, p_strb, strb, first, pend;
    logic [15:0] p_ad;
    int lat_cnt, low_cnt, rel_cnt;
    p_aleh = 1; p_alel = 1; p_strb = 0; first = 0; pend = 0;
    p_ad = '0; lat_cnt = 0; low_cnt = 0; rel_cnt = 0;
    wr_data = 16'h1234;
    forever begin
      @(negedge clk);
      if (pend) wr_data = wr_data + 16'h1111;
      pend = 0;
      strb = !(rd_n && wr_n);
      if (p_aleh && !aleh_n && ph_idx < 16) begin
        check(ad_oe && alel_n && ad_out == exp_lo[ph_idx], "R2 low address half", ad_out, exp_lo[ph_idx]);
        check(p_ad == exp_hi[ph_idx], "R2 high address half", p_ad, exp_hi[ph_idx]);
        ph_idx++;
      end
      if (p_alel && !alel_n) begin
        lat_cnt = 1; first = 1;
      end else if (first && !strb && !alel_n) begin
        lat_cnt++;
      end
      if (strb && !p_strb) begin
        if (first) begin
          check(lat_cnt == exp_lat + 1, "R3 R7 latency cycles", lat_cnt, exp_lat + 1);
          first = 0;
        end else begin
          check(rel_cnt == exp_rls + 1, "R5 release between strobes", rel_cnt, exp_rls + 1);
        end
        low_cnt = 1;
      end else if (strb) begin
        low_cnt++;
      end
      if (!strb && p_strb) begin
        check(low_cnt == exp_pwd + 1, "R4 strobe low cycles", low_cnt, exp_pwd + 1);
        rel_cnt = 1;
        word_cnt++;
      end else if (!strb && !aleh_n && !first) begin
        rel_cnt++;
      end
      if (!p_aleh && aleh_n) begin
        if (word_cnt == exp_words)
          check(done === 1'b1, "R10 done after last release", done, 1);
        else
          check(done === 1'b0, "R6 page crossing without done", done, 0);
        check(rel_cnt == exp_rls + 1, "R5 release before address end", rel_cnt, exp_rls + 1);
      end
      if (!rd_n && ad_oe) rd_oe_bad = 1;
      if (wr_take) begin
        check(!wr_n && ad_oe && ad_out == wr_data, "R8 write data on bus", ad_out, wr_data);
        take_cnt++;
        pend = 1;
      end
      if (rd_valid && rd_idx < 16) begin
        check(rd_data == exp_rd[rd_idx], "R9 read word", rd_data, exp_rd[rd_idx]);
        rd_idx++;
      end
      p_aleh = aleh_n; p_alel = alel_n; p_strb = strb; p_ad = ad_out;
    end
  end

  function automatic bit in_set2(input logic [31:0] a);
    return (a >= 32'h0500_0000 && a <= 32'h05FF_FFFF) || (a >= 32'h0800_0000 && a <= 32'h0FFF_FFFF);
  endfunction

  task automatic run_xfer(input logic [31:0] a, input int n, input bit w, input bit drv,
                          input logic [15:0] din, input bit noise);
    bit d2;
    int pg, nph, t;
    logic [31:0] mask, cur, pbase;
    d2 = in_set2(a);
    exp_lat = d2 ? int'(c2_lat) : int'(c1_lat);
    exp_pwd = d2 ? int'(c2_pwd) : int'(c1_pwd);
    exp_rls = d2 ? int'(c2_rls) : int'(c1_rls);
    pg      = d2 ? int'(c2_pgs) : int'(c1_pgs);
    mask = (32'd1 << (pg + 2)) - 32'd1;
    cur = a; pbase = a; nph = 0;
    for (int i = 0; i < n; i++) begin
      if (i == 0 || (cur & mask) == 0) begin
        pbase = cur;
        exp_hi[nph] = cur[31:16];
        exp_lo[nph] = cur[15:0];
        nph++;
      end
      exp_rd[i] = drv ? din : pbase[15:0];
      cur = cur + 32'd2;
    end
    exp_words = n; ph_idx = 0; word_cnt = 0; rd_idx = 0; take_cnt = 0; rd_oe_bad = 0;
    ad_in = din; ad_in_drv = drv;
    @(negedge clk);
    req_addr = a; req_count = 16'(n); req_write = w; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    t = 0;
    while (done !== 1'b1 && t < 5000) begin
      @(negedge clk);
      t++;
      if (noise && busy) begin
        req_valid = 1; req_addr = 32'h0500_0000; req_count = 16'd4; req_write = !w;
      end
    end
    req_valid = 0;
    check(done === 1'b1, "R10 transfer completes", done, 1);
    @(negedge clk);
    check(done === 1'b0 && !busy && aleh_n && alel_n, "R10 done is one cycle", done, 0);
    @(negedge clk);
    check(ph_idx == nph, "R6 R12 address phase count", ph_idx, nph);
    check(word_cnt == n, "R4 strobes per transfer", word_cnt, n);
    if (w) begin
      check(take_cnt == n, "R8 words taken", take_cnt, n);
    end else begin
      check(rd_idx == n, "R9 words returned", rd_idx, n);
      check(!rd_oe_bad, "R9 bus released while reading", rd_oe_bad, 0);
    end
  endtask

  // {addr, count, write, device drives}
  localparam logic [41:0] VEC [8] = '{
    {32'h1000_0000, 8'd1, 1'b0, 1'b1},
    {32'h1000_0004, 8'd5, 1'b0, 1'b0},
    {32'h0500_0000, 8'd3, 1'b1, 1'b0},
    {32'h0800_0002, 8'd2, 1'b0, 1'b0},
    {32'h0600_0000, 8'd2, 1'b1, 1'b0},
    {32'h04FF_FFFE, 8'd1, 1'b0, 1'b1},
    {32'h0FFF_FFFE, 8'd1, 1'b1, 1'b0},
    {32'h05FF_FFFC, 8'd3, 1'b0, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_addr = '0; req_count = '0; req_write = 0;
    ad_in = '0; ad_in_drv = 0; exp_words = 0;
    c1_lat = 8'd3; c1_pwd = 8'd2; c1_rls = 2'd1; c1_pgs = 4'd1;
    c2_lat = 8'd5; c2_pwd = 8'd1; c2_rls = 2'd2; c2_pgs = 4'd0;
    repeat (3) @(negedge clk);
    check(aleh_n && alel_n && rd_n && wr_n && !ad_oe && !busy && !done,
          "R1 outputs during reset", {aleh_n, alel_n, rd_n, wr_n, ad_oe, busy, done}, 7'b1111000);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(aleh_n && alel_n && rd_n && wr_n && !ad_oe && !busy && !done,
          "R1 idle after reset", {aleh_n, alel_n, rd_n, wr_n, ad_oe, busy, done}, 7'b1111000);

    for (int i = 0; i < 8; i++) begin
      run_xfer(VEC[i][41:10], int'(VEC[i][9:2]), VEC[i][1], VEC[i][0], 16'hC000 + 16'(i), 0);
    end

    // R11: zero-count request
    @(negedge clk);
    req_addr = 32'h1000_0000; req_count = 16'd0; req_write = 0; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    check(!busy && aleh_n, "R11 zero count ignored", busy, 0);

    // R11: requests while busy are ignored
    run_xfer(32'h1000_0000, 2, 1'b0, 1'b0, 16'h0, 1);
    repeat (3) @(negedge clk);
    check(!busy && aleh_n, "R11 no transfer from requests while busy", busy, 0);

    // smallest timing values, two-halfword pages
    c1_lat = 8'd0; c1_pwd = 8'd0; c1_rls = 2'd0; c1_pgs = 4'd0;
    run_xfer(32'h1000_0000, 3, 1'b0, 1'b0, 16'h0, 0);
    run_xfer(32'h1000_0002, 3, 1'b1, 1'b0, 16'h0, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule